// File: doc/BRIEF.md
# Tug-of-War Game Controller

This block runs a two-player tug-of-war game on a row of seven LEDs. Exactly one LED is lit. After reset the light sits in the middle. Each player has one button. A press by the left player pulls the light one step toward the left end of the row. A press by the right player pulls it one step toward the right end. The player who pulls the light onto their own end LED wins. The block then holds that result until the next reset.

Each raw button passes through a rising-edge pulse stage. A press therefore counts once, however long the button is held. When both players press in the same cycle, the two pulls cancel and the light does not move. The position is kept as a small binary state. A registered output stage decodes it into the one-hot LED vector and the two win flags. The row length is a parameter, and it must be odd so that a single middle LED exists.

Top module: `tug_game`

## Requirements
- R1: `led` is one-hot in every cycle after reset. Light position p (0..6) lights `led[p]`. `led[6]` is the left end and `led[0]` is the right end.
- R2: Reset is synchronous and active high. After any clock edge with `rst` high, `led` equals 7'b0001000 (position 3), and `win_left` and `win_right` are low.
- R3: A left press moves the light one position toward `led[6]`. A right press moves it one position toward `led[0]`. The new LED appears after the second rising edge that follows the first edge at which the button is sampled high. At the edge that samples the button and at the edge after it, `led` is unchanged.
- R4: A button held high for many cycles moves the light only once. A further move needs that button to be sampled low at one or more edges and then sampled high again.
- R5: If the left and right presses are detected at the same edge, the light does not move.
- R6: When the light reaches position 6, `win_left` goes high in the same cycle that `led[6]` lights. When it reaches position 0, `win_right` goes high together with `led[0]`. Neither flag is high at any other position.
- R7: While either win flag is high, button activity of any kind leaves `led` and both flags unchanged until reset.
- R8: A button that is high during reset and stays high after reset is released causes no move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_left | input | 1 | Raw level from the left player's button |
| btn_right | input | 1 | Raw level from the right player's button |
| led | output | 7 | One-hot light position, bit 6 = left end |
| win_left | output | 1 | High while the left player has won |
| win_right | output | 1 | High while the right player has won |

## Verification
The assertions assume two things about the inputs. Reset is held high from the first clock edge for at least two cycles. Both button levels are already synchronous to `clk`, so the edge stage never sees a metastable level. The bench meets both conditions. It drives the buttons only on falling edges and holds reset for three cycles at the start and at every restart. Its stimulus reaches the ordering cases the requirements single out: simultaneous presses, long holds, a one-cycle release between holds, presses after a win, and a button held across reset.

// File: rtl/tug_pkg.sv
package tug_pkg;

  // Requested step of the light for one cycle
  typedef enum logic [1:0] {
    MV_HOLD  = 2'd0,
    MV_LEFT  = 2'd1,
    MV_RIGHT = 2'd2
  } move_e;

  // Resolve the two detected presses into a single move
  function automatic move_e resolve_move(input logic pl, input logic pr);
    if (pl && !pr)      return MV_LEFT;
    else if (pr && !pl) return MV_RIGHT;
    else                return MV_HOLD;
  endfunction

endpackage

// File: rtl/tug_rise_pulse.sv
// One-cycle pulse on each 0->1 transition of every input lane.
module tug_rise_pulse #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] pulse
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic last_q;
    logic pulse_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        // Arm with the current level: a button held through reset gives no edge
        last_q  <= raw[g];
        pulse_q <= 1'b0;
      end else begin
        last_q  <= raw[g];
        pulse_q <= raw[g] & ~last_q;
      end
    end

    assign pulse[g] = pulse_q;
  end

endmodule

// File: rtl/tug_pos_fsm.sv
// Light position register; the ends are terminal until reset.
module tug_pos_fsm
  import tug_pkg::*;
#(
  parameter int N_LED = 7,
  localparam int POS_W = $clog2(N_LED),
  localparam int MID   = (N_LED - 1) / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_l,
  input  logic             pulse_r,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] POS_MID  = POS_W'(MID);
  localparam logic [POS_W-1:0] POS_LEFT = POS_W'(N_LED - 1);
  localparam logic [POS_W-1:0] POS_RGHT = '0;

  logic [POS_W-1:0] pos_q, pos_d;
  logic             at_end;
  move_e            mv;

  assign at_end = (pos_q == POS_LEFT) || (pos_q == POS_RGHT);
  assign mv     = resolve_move(pulse_l, pulse_r);

  always_comb begin
    pos_d = pos_q;
    if (!at_end) begin
      unique case (mv)
        MV_LEFT:  pos_d = pos_q + 1'b1;
        MV_RIGHT: pos_d = pos_q - 1'b1;
        default:  pos_d = pos_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pos_q <= POS_MID;
    else     pos_q <= pos_d;
  end

  assign pos = pos_q;

endmodule

// File: rtl/tug_led_out.sv
// Registered one-hot decode of the position plus the win flags.
module tug_led_out #(
  parameter int N_LED = 7,
  localparam int POS_W = $clog2(N_LED),
  localparam int MID   = (N_LED - 1) / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos,
  output logic [N_LED-1:0] led,
  output logic             win_l,
  output logic             win_r
);

  logic [N_LED-1:0] led_d, led_q;
  logic             wl_q, wr_q;

  for (genvar i = 0; i < N_LED; i++) begin : g_dec
    assign led_d[i] = (pos == POS_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led_q <= N_LED'(1) << MID;
      wl_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      led_q <= led_d;
      wl_q  <= led_d[N_LED-1];
      wr_q  <= led_d[0];
    end
  end

  assign led   = led_q;
  assign win_l = wl_q;
  assign win_r = wr_q;

endmodule

// File: rtl/tug_game.sv
module tug_game #(
  parameter int N_LED = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_left,
  input  logic             btn_right,
  output logic [N_LED-1:0] led,
  output logic             win_left,
  output logic             win_right
);

  localparam int POS_W = $clog2(N_LED);

  logic [1:0]       pulse_vec;   // [1] = left, [0] = right
  logic [POS_W-1:0] pos_q;

  tug_rise_pulse #(.LANES(2)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .raw   ({btn_left, btn_right}),
    .pulse (pulse_vec)
  );

  tug_pos_fsm #(.N_LED(N_LED)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .pulse_l (pulse_vec[1]),
    .pulse_r (pulse_vec[0]),
    .pos     (pos_q)
  );

  tug_led_out #(.N_LED(N_LED)) u_out (
    .clk   (clk),
    .rst   (rst),
    .pos   (pos_q),
    .led   (led),
    .win_l (win_left),
    .win_r (win_right)
  );

endmodule

// File: rtl/tug_game_chk.sv
module tug_game_chk #(
  parameter int N_LED = 7,
  localparam int POS_W = $clog2(N_LED),
  localparam int MID   = (N_LED - 1) / 2
) (
  input logic             clk,
  input logic             rst,
  input logic [N_LED-1:0] led,
  input logic             win_left,
  input logic             win_right,
  input logic             pulse_l,
  input logic             pulse_r,
  input logic [POS_W-1:0] pos
);

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(led) == 1);

  p_reset_mid_r2: assert property (@(posedge clk)
    rst |=> (led == (N_LED'(1) << MID)) && !win_left && !win_right);

  p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
    (led != $past(led)) |->
      ((led == ($past(led) << 1)) || (led == ($past(led) >> 1))));

  p_pulse_once_l_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_l |=> !pulse_l);

  p_pulse_once_r_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_r |=> !pulse_r);

  p_both_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pulse_l && pulse_r) |=> $stable(pos));

  p_win_left_led_r6: assert property (@(posedge clk) disable iff (rst)
    win_left |-> led[N_LED-1] && !win_right);

  p_win_right_led_r6: assert property (@(posedge clk) disable iff (rst)
    win_right |-> led[0] && !win_left);

  p_win_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (win_left || win_right) |=>
      $stable(led) && $stable(win_left) && $stable(win_right));

endmodule

bind tug_game tug_game_chk #(.N_LED(N_LED)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .led       (led),
  .win_left  (win_left),
  .win_right (win_right),
  .pulse_l   (pulse_vec[1]),
  .pulse_r   (pulse_vec[0]),
  .pos       (pos_q)
);

// File: tb/sim_tug_game.sv
`timescale 1ns/1ps
module sim_tug_game;

  localparam int N = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bl  = 1'b0;
  logic br  = 1'b0;
  logic [N-1:0] led;
  logic win_left, win_right;

  always #10 clk = ~clk;   // 50 MHz

  tug_game #(.N_LED(N)) u0 (
    .clk(clk), .rst(rst), .btn_left(bl), .btn_right(br),
    .led(led), .win_left(win_left), .win_right(win_right)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  bit    model_on = 0;
  string cur_req = "R1";

  // Behavioural model: integer light position with a two-deep delay queue
  int m_prev_l, m_prev_r, m_hit_l, m_hit_r, m_pos;
  int m_shown[$];

  always @(posedge clk) begin
    if (rst) begin
      m_prev_l = bl; m_prev_r = br;
      m_hit_l  = 0;  m_hit_r  = 0;
      m_pos    = 3;
      m_shown  = {3, 3};
      model_on = 1;
    end else begin
      // presses detected at the previous edge act now
      if (m_pos != 0 && m_pos != N-1) begin
        if (m_hit_l && !m_hit_r) m_pos = m_pos + 1;
        if (m_hit_r && !m_hit_l) m_pos = m_pos - 1;
      end
      m_hit_l  = (bl && !m_prev_l);
      m_hit_r  = (br && !m_prev_r);
      m_prev_l = bl; m_prev_r = br;
      m_shown.push_back(m_pos);
      void'(m_shown.pop_front());
    end
  end

  task automatic check(string req, logic [N+1:0] got, logic [N+1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {win_l,win_r,led}=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [N+1:0] expect_vec(int p);
    return {p == N-1, p == 0, N'(1) << p};
  endfunction

  // Cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (model_on && !done)
      check(cur_req, {win_left, win_right, led}, expect_vec(m_shown[0]));
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(bit l, bit r);
    @(negedge clk); bl = l; br = r;
    @(negedge clk); bl = 0; br = 0;
    wait_n(3);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    wait_n(3);
    rst = 0;
  endtask

  initial begin
    // R2: reset state
    wait_n(3);
    cur_req = "R2";
    check("R2", {win_left, win_right, led}, {2'b00, 7'b0001000});
    rst = 0;
    wait_n(2);

    // R3: latency and direction of a left press
    cur_req = "R3";
    bl = 1;
    @(negedge clk); check("R3", {win_left, win_right, led}, {2'b00, 7'b0001000});
    bl = 0;
    @(negedge clk); check("R3", {win_left, win_right, led}, {2'b00, 7'b0001000});
    @(negedge clk); check("R3", {win_left, win_right, led}, {2'b00, 7'b0010000});
    wait_n(2);
    press(0, 1);
    check("R3", {win_left, win_right, led}, {2'b00, 7'b0001000});

    // R4: long hold gives one step; a one-cycle drop re-arms
    cur_req = "R4";
    @(negedge clk); bl = 1;
    wait_n(10);
    check("R4", {win_left, win_right, led}, {2'b00, 7'b0010000});
    bl = 0; @(negedge clk); bl = 1;
    wait_n(4);
    check("R4", {win_left, win_right, led}, {2'b00, 7'b0100000});
    bl = 0; wait_n(2);
    press(0, 1);
    check("R4", {win_left, win_right, led}, {2'b00, 7'b0010000});

    // R5: simultaneous presses cancel
    cur_req = "R5";
    press(1, 1);
    check("R5", {win_left, win_right, led}, {2'b00, 7'b0010000});
    // staggered presses do both act
    @(negedge clk); bl = 1; @(negedge clk); br = 1; @(negedge clk); bl = 0; br = 0;
    wait_n(3);
    check("R5", {win_left, win_right, led}, {2'b00, 7'b0010000});

    // R6: left wins
    cur_req = "R6";
    press(1, 0);
    check("R6", {win_left, win_right, led}, {2'b00, 7'b0100000});
    press(1, 0);
    check("R6", {win_left, win_right, led}, {2'b10, 7'b1000000});

    // R7: locked after a win
    cur_req = "R7";
    press(0, 1); press(0, 1); press(1, 1); press(1, 0);
    @(negedge clk); br = 1; wait_n(6); br = 0; wait_n(3);
    check("R7", {win_left, win_right, led}, {2'b10, 7'b1000000});

    // R2: reset from a won game
    cur_req = "R2";
    do_reset();
    check("R2", {win_left, win_right, led}, {2'b00, 7'b0001000});

    // R6: right wins
    cur_req = "R6";
    press(0, 1); press(0, 1);
    check("R6", {win_left, win_right, led}, {2'b00, 7'b0000010});
    press(0, 1);
    check("R6", {win_left, win_right, led}, {2'b01, 7'b0000001});

    cur_req = "R7";
    press(1, 0); press(1, 1);
    check("R7", {win_left, win_right, led}, {2'b01, 7'b0000001});

    // R8: buttons held through reset make no move
    cur_req = "R8";
    @(negedge clk); bl = 1; br = 0;
    do_reset();
    wait_n(6);
    check("R8", {win_left, win_right, led}, {2'b00, 7'b0001000});
    bl = 0; br = 1;
    do_reset();
    wait_n(6);
    check("R8", {win_left, win_right, led}, {2'b00, 7'b0001000});
    br = 0; wait_n(2);
    press(0, 1);
    check("R8", {win_left, win_right, led}, {2'b00, 7'b0000100});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule